// File: doc/BRIEF.md
# Codec Power-Mode Sequencer

This block runs on the host side and steps an external audio converter through its three power modes: hardware off, sleep, and active recording. It drives the converter's active-low shutdown line and a gate for the frame and bit clocks. All register traffic goes through an abstract command port with a valid/ready handshake. The port carries read or write, page, address and write data, and returns read data. The physical control bus and the audio data path sit outside the block. Every written value comes from a configuration input, so one netlist serves any channel or slot plan.

The block takes three requests (record, sleep, shutdown) and a supplies-good input. A shared millisecond timer, built from a clock-cycles-per-millisecond parameter, enforces the minimum waits between steps. The channel, slot and power-up writes run only on the first activation after a shutdown, because the converter keeps its registers through sleep. The audio clocks stop only after the converter reports, in its status register, that it has reached sleep. If it never does, the block stops in a fault state.

Top module: `codec_mode_seq`

## Requirements
- R1: `shdn_n` is 0 from reset. It rises only while `supplies_good` is 1 and `req_shutdown` is 0.
- R2: After `shdn_n` rises, no command is issued for at least `CYC_PER_MS` cycles. During that time `mode` reads 1 (boot), then 2 (sleep). Mode codes are: 0 off, 1 boot, 2 sleep, 3 active, 4 busy (any transition in progress), 5 fault.
- R3: A record request in sleep first writes page 0, address 2 with `cfg_wake_word`. The next command follows at least 1 ms later.
- R4: On the first activation after shutdown, three page 0 writes follow the wake write, in this order: address 115 with `cfg_chan_en`, address 116 with `cfg_slot_en`, address 117 with `cfg_power_en`.
- R5: `clk_en` rises only after the wake write. On the first activation it also waits for the address 117 write.
- R6: At least 10 ms after `clk_en` rises, the block writes address 100 with `cfg_diag_on`. `mode` then reads 3.
- R7: A sleep request in active mode issues three commands in order: a write of address 100 with `cfg_diag_off`, a write of address 2 with `cfg_sleep_word`, and, at least 20 ms later, a read of address 119.
- R8: `clk_en` falls only after an address 119 read whose data has every bit of `STATUS_MASK` set (default: bit 7). `mode` then reads 2.
- R9: A later wake from sleep issues only the address 2 wake write and the address 100 diagnostic enable. It skips addresses 115 to 117.
- R10: `req_shutdown` acts from any state. At the next edge `shdn_n`, `clk_en` and `fault` are 0 and `mode` is 0. A later release restarts from R1 and repeats the full R4 setup.
- R11: Record is ignored outside sleep mode, and sleep is ignored outside active mode. Neither issues any command.
- R12: If a status read fails the R8 test, the block reads address 119 again at least 1 ms later, up to `RETRIES` extra reads. `clk_en` stays 1 meanwhile.
- R13: When the extra reads run out, `fault` goes to 1 and stays there, and `mode` reads 5, until a shutdown request. Record requests are ignored in this state.
- R14: Only one command is outstanding at a time. `cmd_valid` and its fields hold steady until `cmd_ready`. Read data is taken in the cycle where valid and ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supplies_good | input | 1 | Converter supplies are settled |
| req_record | input | 1 | Request active recording |
| req_sleep | input | 1 | Request sleep |
| req_shutdown | input | 1 | Request hardware shutdown (level) |
| cfg_wake_word | input | 8 | Value written to address 2 to leave sleep |
| cfg_sleep_word | input | 8 | Value written to address 2 to enter sleep |
| cfg_chan_en | input | 8 | Input channel enables (address 115) |
| cfg_slot_en | input | 8 | Serial output slot enables (address 116) |
| cfg_power_en | input | 8 | Converter, bias and PLL power-up (address 117) |
| cfg_diag_on | input | 8 | Diagnostic enable value (address 100) |
| cfg_diag_off | input | 8 | Diagnostic disable value (address 100) |
| cmd_valid | output | 1 | Command request |
| cmd_ready | input | 1 | Command accepted |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_page | output | 8 | Register page |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 8 | Write data |
| cmd_rdata | input | 8 | Read data, valid with cmd_ready |
| shdn_n | output | 1 | Active-low converter shutdown |
| clk_en | output | 1 | Audio frame/bit clock enable |
| mode | output | 3 | Current mode code (see R2) |
| fault | output | 1 | Sticky sleep-confirmation failure |

## Verification
Every output is registered, so each result has a fixed latency. A shutdown request shows on `shdn_n`, `clk_en` and `fault` at the first edge, and the bench samples them at the following falling edge. After an acceptance the next command appears three edges later, plus the timer's whole milliseconds where a wait applies. The bench therefore does not check exact cycle numbers. It checks each gap against a window from the required minimum up to a few cycles more, which still allows for its own randomised ready latency. Command content and order are compared against a queue of expected commands at every acceptance. The other properties are checked on every falling edge: clock gating needs `shdn_n` high, no traffic while `shdn_n` is low, and a valid request is held until it is accepted.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int MS_W   = 5;

  localparam logic [BYTE_W-1:0] PAGE_MAIN   = 8'd0;
  localparam logic [BYTE_W-1:0] ADDR_PWRMD  = 8'd2;
  localparam logic [BYTE_W-1:0] ADDR_DIAG   = 8'd100;
  localparam logic [BYTE_W-1:0] ADDR_CHAN   = 8'd115;
  localparam logic [BYTE_W-1:0] ADDR_SLOT   = 8'd116;
  localparam logic [BYTE_W-1:0] ADDR_POWER  = 8'd117;
  localparam logic [BYTE_W-1:0] ADDR_STATUS = 8'd119;

  localparam logic [MS_W-1:0] WAIT_INIT  = 5'd1;
  localparam logic [MS_W-1:0] WAIT_BIAS  = 5'd10;
  localparam logic [MS_W-1:0] WAIT_DRAIN = 5'd20;
  localparam logic [MS_W-1:0] WAIT_RETRY = 5'd1;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_BOOT   = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_ACTIVE = 3'd3,
    MODE_BUSY   = 3'd4,
    MODE_FAULT  = 3'd5
  } mode_e;

  typedef enum logic [4:0] {
    ST_OFF,
    ST_BOOT,
    ST_SLEEP,
    ST_WAKE_WR,
    ST_WAKE_T,
    ST_CHAN_WR,
    ST_SLOT_WR,
    ST_PWR_WR,
    ST_BIAS_T,
    ST_DIAG_ON_WR,
    ST_ACTIVE,
    ST_DIAG_OFF_WR,
    ST_SLEEP_WR,
    ST_DRAIN_T,
    ST_STAT_RD,
    ST_RETRY_T,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] page;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } cmd_t;

  function automatic mode_e mode_of(seq_state_e s);
    case (s)
      ST_OFF:    return MODE_OFF;
      ST_BOOT:   return MODE_BOOT;
      ST_SLEEP:  return MODE_SLEEP;
      ST_ACTIVE: return MODE_ACTIVE;
      ST_FAULT:  return MODE_FAULT;
      default:   return MODE_BUSY;
    endcase
  endfunction

endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer
  import codec_seq_pkg::*;
#(
  parameter int CYC_PER_MS = 100000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            start,
  input  logic [MS_W-1:0] ms_load,
  output logic            expired
);

  localparam int CYC_W = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cyc_q   <= '0;
      ms_q    <= '0;
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        cyc_q <= '0;
        ms_q  <= ms_load;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cyc_q == CYC_LAST) begin
          cyc_q <= '0;
          if (ms_q <= MS_W'(1)) begin
            run_q   <= 1'b0;
            expired <= 1'b1;
          end else begin
            ms_q <= ms_q - MS_W'(1);
          end
        end else begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/seq_cmd_issuer.sv
module seq_cmd_issuer
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              issue,
  input  cmd_t              issue_cmd,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [BYTE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_wdata,
  input  logic [BYTE_W-1:0] cmd_rdata,
  output logic              done,
  output logic [BYTE_W-1:0] rd_word
);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
      cmd_page  <= '0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      done      <= 1'b0;
      rd_word   <= '0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
        done      <= 1'b1;
        rd_word   <= cmd_rdata;
      end else if (issue && !cmd_valid) begin
        cmd_valid <= 1'b1;
        cmd_write <= issue_cmd.wr;
        cmd_page  <= issue_cmd.page;
        cmd_addr  <= issue_cmd.addr;
        cmd_wdata <= issue_cmd.wdata;
      end
    end
  end

endmodule

// File: rtl/codec_mode_seq.sv
module codec_mode_seq
  import codec_seq_pkg::*;
#(
  parameter int                CYC_PER_MS  = 100000,
  parameter int                RETRIES     = 3,
  parameter logic [BYTE_W-1:0] STATUS_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supplies_good,
  input  logic              req_record,
  input  logic              req_sleep,
  input  logic              req_shutdown,
  input  logic [BYTE_W-1:0] cfg_wake_word,
  input  logic [BYTE_W-1:0] cfg_sleep_word,
  input  logic [BYTE_W-1:0] cfg_chan_en,
  input  logic [BYTE_W-1:0] cfg_slot_en,
  input  logic [BYTE_W-1:0] cfg_power_en,
  input  logic [BYTE_W-1:0] cfg_diag_on,
  input  logic [BYTE_W-1:0] cfg_diag_off,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [BYTE_W-1:0] cmd_page,
  output logic [BYTE_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_wdata,
  input  logic [BYTE_W-1:0] cmd_rdata,
  output logic              shdn_n,
  output logic              clk_en,
  output logic [2:0]        mode,
  output logic              fault
);

  localparam int RT_W = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1;
  localparam logic [RT_W-1:0] RT_LAST = RT_W'(RETRIES);

  seq_state_e      state_q, state_d;
  logic            cfg_done_q;
  logic [RT_W-1:0] retry_q;
  logic            inflight_q;

  logic            tmr_start, tmr_expired;
  logic [MS_W-1:0] tmr_ms;
  logic            clk_on, clk_off, set_cfg, set_fault, retry_clr, retry_inc;

  logic              is_cmd;
  cmd_t              cur_cmd;
  logic              cmd_done;
  logic [BYTE_W-1:0] rd_word;
  logic              status_ok;

  // command that belongs to each command state
  always_comb begin
    is_cmd  = 1'b1;
    cur_cmd = '{wr: 1'b1, page: PAGE_MAIN, addr: ADDR_PWRMD, wdata: cfg_wake_word};
    case (state_q)
      ST_WAKE_WR:     cur_cmd.wdata = cfg_wake_word;
      ST_CHAN_WR:     begin cur_cmd.addr = ADDR_CHAN;  cur_cmd.wdata = cfg_chan_en;  end
      ST_SLOT_WR:     begin cur_cmd.addr = ADDR_SLOT;  cur_cmd.wdata = cfg_slot_en;  end
      ST_PWR_WR:      begin cur_cmd.addr = ADDR_POWER; cur_cmd.wdata = cfg_power_en; end
      ST_DIAG_ON_WR:  begin cur_cmd.addr = ADDR_DIAG;  cur_cmd.wdata = cfg_diag_on;  end
      ST_DIAG_OFF_WR: begin cur_cmd.addr = ADDR_DIAG;  cur_cmd.wdata = cfg_diag_off; end
      ST_SLEEP_WR:    cur_cmd.wdata = cfg_sleep_word;
      ST_STAT_RD:     begin cur_cmd.wr = 1'b0; cur_cmd.addr = ADDR_STATUS; cur_cmd.wdata = '0; end
      default:        is_cmd = 1'b0;
    endcase
  end

  assign status_ok = ((rd_word & STATUS_MASK) == STATUS_MASK);

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    tmr_ms    = '0;
    clk_on    = 1'b0;
    clk_off   = 1'b0;
    set_cfg   = 1'b0;
    set_fault = 1'b0;
    retry_clr = 1'b0;
    retry_inc = 1'b0;
    case (state_q)
      ST_OFF: if (supplies_good) begin
        state_d = ST_BOOT; tmr_start = 1'b1; tmr_ms = WAIT_INIT;
      end
      ST_BOOT:  if (tmr_expired) state_d = ST_SLEEP;
      ST_SLEEP: if (req_record)  state_d = ST_WAKE_WR;
      ST_WAKE_WR: if (cmd_done) begin
        state_d = ST_WAKE_T; tmr_start = 1'b1; tmr_ms = WAIT_INIT;
      end
      ST_WAKE_T: if (tmr_expired) begin
        if (cfg_done_q) begin
          state_d = ST_BIAS_T; tmr_start = 1'b1; tmr_ms = WAIT_BIAS; clk_on = 1'b1;
        end else begin
          state_d = ST_CHAN_WR;
        end
      end
      ST_CHAN_WR: if (cmd_done) state_d = ST_SLOT_WR;
      ST_SLOT_WR: if (cmd_done) state_d = ST_PWR_WR;
      ST_PWR_WR: if (cmd_done) begin
        state_d = ST_BIAS_T; tmr_start = 1'b1; tmr_ms = WAIT_BIAS;
        clk_on = 1'b1; set_cfg = 1'b1;
      end
      ST_BIAS_T:     if (tmr_expired) state_d = ST_DIAG_ON_WR;
      ST_DIAG_ON_WR: if (cmd_done)    state_d = ST_ACTIVE;
      ST_ACTIVE:     if (req_sleep)   state_d = ST_DIAG_OFF_WR;
      ST_DIAG_OFF_WR: if (cmd_done)   state_d = ST_SLEEP_WR;
      ST_SLEEP_WR: if (cmd_done) begin
        state_d = ST_DRAIN_T; tmr_start = 1'b1; tmr_ms = WAIT_DRAIN; retry_clr = 1'b1;
      end
      ST_DRAIN_T: if (tmr_expired) state_d = ST_STAT_RD;
      ST_STAT_RD: if (cmd_done) begin
        if (status_ok) begin
          state_d = ST_SLEEP; clk_off = 1'b1;
        end else if (retry_q == RT_LAST) begin
          state_d = ST_FAULT; set_fault = 1'b1;
        end else begin
          state_d = ST_RETRY_T; tmr_start = 1'b1; tmr_ms = WAIT_RETRY; retry_inc = 1'b1;
        end
      end
      ST_RETRY_T: if (tmr_expired) state_d = ST_STAT_RD;
      ST_FAULT:   state_d = ST_FAULT;
      default:    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || req_shutdown) begin
      state_q    <= ST_OFF;
      shdn_n     <= 1'b0;
      clk_en     <= 1'b0;
      cfg_done_q <= 1'b0;
      fault      <= 1'b0;
      retry_q    <= '0;
      inflight_q <= 1'b0;
      mode       <= MODE_OFF;
    end else begin
      state_q <= state_d;
      mode    <= mode_of(state_d);
      if (state_q == ST_OFF && state_d == ST_BOOT) shdn_n <= 1'b1;
      if (clk_on)    clk_en     <= 1'b1;
      if (clk_off)   clk_en     <= 1'b0;
      if (set_cfg)   cfg_done_q <= 1'b1;
      if (set_fault) fault      <= 1'b1;
      if (retry_clr)      retry_q <= '0;
      else if (retry_inc) retry_q <= retry_q + RT_W'(1);
      if (is_cmd && !inflight_q) inflight_q <= 1'b1;
      else if (cmd_done)         inflight_q <= 1'b0;
    end
  end

  seq_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .abort   (req_shutdown),
    .start   (tmr_start),
    .ms_load (tmr_ms),
    .expired (tmr_expired)
  );

  seq_cmd_issuer u_issuer (
    .clk       (clk),
    .rst       (rst),
    .abort     (req_shutdown),
    .issue     (is_cmd && !inflight_q),
    .issue_cmd (cur_cmd),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_page  (cmd_page),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .done      (cmd_done),
    .rd_word   (rd_word)
  );

endmodule

// File: rtl/codec_mode_seq_chk.sv
module codec_mode_seq_chk
  import codec_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              supplies_good,
  input logic              req_shutdown,
  input logic              shdn_n,
  input logic              clk_en,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [BYTE_W-1:0] cmd_addr,
  input logic [BYTE_W-1:0] cmd_wdata,
  input logic [2:0]        mode,
  input logic              fault
);

  AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $rose(shdn_n) |-> $past(supplies_good) && !$past(req_shutdown)); // R1

  AST_QUIET_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n || mode == MODE_BOOT) |-> !cmd_valid); // R2

  AST_CLOCK_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> shdn_n); // R10

  AST_CLOCK_STOP_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_en) && shdn_n) |-> mode == MODE_SLEEP); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault && !req_shutdown) |=> fault); // R13

  AST_FAULT_MODE: assert property (@(posedge clk) disable iff (rst)
    fault |-> mode == MODE_FAULT); // R13

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !req_shutdown) |=>
      cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_write)); // R14

endmodule

bind codec_mode_seq codec_mode_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .supplies_good (supplies_good),
  .req_shutdown  (req_shutdown),
  .shdn_n        (shdn_n),
  .clk_en        (clk_en),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_write     (cmd_write),
  .cmd_addr      (cmd_addr),
  .cmd_wdata     (cmd_wdata),
  .mode          (mode),
  .fault         (fault)
);

// File: tb/sim_codec_mode_seq.sv
module sim_codec_mode_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 20;
  localparam int RETRIES    = 3;
  localparam int SLACK      = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supplies_good = 1'b0, req_record = 1'b0, req_sleep = 1'b0, req_shutdown = 1'b0;
  logic [7:0] cfg_wake_word = 8'h00, cfg_sleep_word = 8'h01, cfg_chan_en = 8'hC0;
  logic [7:0] cfg_slot_en = 8'h30, cfg_power_en = 8'hE0, cfg_diag_on = 8'hA5, cfg_diag_off = 8'h0F;
  logic cmd_valid, cmd_ready = 1'b0, cmd_write;
  logic [7:0] cmd_page, cmd_addr, cmd_wdata, cmd_rdata = 8'h00;
  logic shdn_n, clk_en, fault;
  logic [2:0] mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_mode_seq #(.CYC_PER_MS(CPM), .RETRIES(RETRIES), .STATUS_MASK(8'h80)) u0 (
    .clk(clk), .rst(rst), .supplies_good(supplies_good), .req_record(req_record),
    .req_sleep(req_sleep), .req_shutdown(req_shutdown),
    .cfg_wake_word(cfg_wake_word), .cfg_sleep_word(cfg_sleep_word),
    .cfg_chan_en(cfg_chan_en), .cfg_slot_en(cfg_slot_en), .cfg_power_en(cfg_power_en),
    .cfg_diag_on(cfg_diag_on), .cfg_diag_off(cfg_diag_off),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_page(cmd_page), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .shdn_n(shdn_n), .clk_en(clk_en), .mode(mode), .fault(fault));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit wr; int addr; int data; } exp_t;
  exp_t expq[$];
  logic [7:0] statq[$];
  int last_acc[256];
  int acc_total = 0, n_reads = 0, last_rd = 0, prev_rd = 0;
  int clk_rise = 0, clk_fall = 0, inv_fail = 0, hold_fail = 0;
  bit prev_clk = 0, prev_v = 0;
  int lat_left = 0, lat_seed = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(bit wr, int addr, int data);
    exp_t e;
    e.wr = wr; e.addr = addr; e.data = data;
    expq.push_back(e);
  endtask

  // responder and monitor: one process on the falling edge
  initial begin
    for (int i = 0; i < 256; i++) last_acc[i] = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!shdn_n && (clk_en || cmd_valid)) inv_fail++;
        if (prev_v && !cmd_ready && !cmd_valid && !req_shutdown) hold_fail++;
      end
      prev_v = cmd_valid;
      if (clk_en && !prev_clk) clk_rise = cyc;
      if (!clk_en && prev_clk) clk_fall = cyc;
      prev_clk = clk_en;
      if (cmd_ready) begin
        cmd_ready = 1'b0;
      end else if (cmd_valid) begin
        if (lat_left > 0) lat_left--;
        else begin
          if (expq.size() == 0) begin
            chk(0, "R11", "unexpected command addr", int'(cmd_addr), -1);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(cmd_write == e.wr && int'(cmd_addr) == e.addr && cmd_page == 8'd0 &&
                (!e.wr || int'(cmd_wdata) == e.data),
                "R4 R7 R9", "command addr/data", int'(cmd_addr)*256 + int'(cmd_wdata),
                e.addr*256 + (e.wr ? e.data : int'(cmd_wdata)));
          end
          last_acc[cmd_addr] = cyc;
          acc_total++;
          if (!cmd_write) begin
            n_reads++; prev_rd = last_rd; last_rd = cyc;
            cmd_rdata = (statq.size() > 0) ? statq.pop_front() : 8'h80;
          end
          cmd_ready = 1'b1;
          lat_seed = (lat_seed + 1) % 3;
          lat_left = lat_seed;
        end
      end
    end
  end

  task automatic pulse_record();
    @(negedge clk); req_record = 1'b1; @(negedge clk); req_record = 1'b0;
  endtask
  task automatic pulse_sleep();
    @(negedge clk); req_sleep = 1'b1; @(negedge clk); req_sleep = 1'b0;
  endtask
  task automatic wait_mode(int m, int limit, string req);
    for (int i = 0; i < limit && int'(mode) != m; i++) @(negedge clk);
    chk(int'(mode) == m, req, "mode reached", int'(mode), m);
  endtask

  task automatic boot_check();
    int t_rel, a0;
    a0 = acc_total;
    for (int i = 0; i < 100 && !shdn_n; i++) @(negedge clk);
    chk(shdn_n == 1'b1, "R1", "shdn_n released with supplies", int'(shdn_n), 1);
    t_rel = cyc;
    chk(int'(mode) == 1, "R2", "boot mode after release", int'(mode), 1);
    wait_mode(2, CPM + SLACK, "R2");
    chk(cyc - t_rel >= CPM - 1 && cyc - t_rel <= CPM + SLACK, "R2", "boot wait cycles", cyc - t_rel, CPM);
    chk(acc_total == a0, "R2", "no command during boot", acc_total - a0, 0);
  endtask

  task automatic full_activation(string req);
    push_exp(1, 2, cfg_wake_word);
    push_exp(1, 115, cfg_chan_en);
    push_exp(1, 116, cfg_slot_en);
    push_exp(1, 117, cfg_power_en);
    push_exp(1, 100, cfg_diag_on);
    pulse_record();
    wait_mode(3, 20*CPM, req);
    chk(expq.size() == 0, req, "full setup commands seen", expq.size(), 0);
  endtask

  task automatic sleep_expect(int nreads);
    push_exp(1, 100, cfg_diag_off);
    push_exp(1, 2, cfg_sleep_word);
    for (int i = 0; i < nreads; i++) push_exp(0, 119, 0);
  endtask

  initial begin
    int a0, r0, s115;
    repeat (3) @(negedge clk);
    chk(shdn_n == 0 && clk_en == 0 && cmd_valid == 0 && fault == 0 && mode == 3'd0,
        "R1", "reset state", {shdn_n, clk_en, cmd_valid, fault}, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(shdn_n == 0, "R1", "shdn_n low without supplies", int'(shdn_n), 0);
    req_shutdown = 1'b1; supplies_good = 1'b1;
    repeat (10) @(negedge clk);
    chk(shdn_n == 0, "R1", "shdn_n low while shutdown held", int'(shdn_n), 0);
    req_shutdown = 1'b0;
    boot_check();

    // R11: sleep request in sleep mode
    a0 = acc_total; pulse_sleep(); repeat (40) @(negedge clk);
    chk(acc_total == a0 && mode == 3'd2, "R11", "sleep ignored in sleep", acc_total - a0, 0);

    // first activation, with a sleep request injected while busy (R11)
    push_exp(1, 2, cfg_wake_word);
    push_exp(1, 115, cfg_chan_en);
    push_exp(1, 116, cfg_slot_en);
    push_exp(1, 117, cfg_power_en);
    push_exp(1, 100, cfg_diag_on);
    pulse_record();
    for (int i = 0; i < 20*CPM && !clk_en; i++) @(negedge clk);
    pulse_sleep();
    wait_mode(3, 20*CPM, "R6");
    chk(expq.size() == 0, "R11", "busy sleep request ignored, setup complete", expq.size(), 0);
    chk(last_acc[115] - last_acc[2] >= CPM && last_acc[115] - last_acc[2] <= CPM + SLACK,
        "R3", "wake to next command gap", last_acc[115] - last_acc[2], CPM);
    chk(last_acc[2] < last_acc[115] && last_acc[115] < last_acc[116] && last_acc[116] < last_acc[117],
        "R4", "setup order", last_acc[117] - last_acc[115], 2);
    chk(clk_rise > last_acc[117] && clk_rise > last_acc[2], "R5", "clock after setup writes",
        clk_rise, last_acc[117] + 1);
    chk(last_acc[100] - clk_rise >= 10*CPM && last_acc[100] - clk_rise <= 10*CPM + SLACK,
        "R6", "bias wait before diag enable", last_acc[100] - clk_rise, 10*CPM);

    // R11: record in active mode
    a0 = acc_total; pulse_record(); repeat (40) @(negedge clk);
    chk(acc_total == a0 && mode == 3'd3, "R11", "record ignored in active", acc_total - a0, 0);

    // normal sleep entry
    sleep_expect(1);
    pulse_sleep();
    wait_mode(2, 40*CPM, "R8");
    chk(expq.size() == 0, "R7", "sleep command sequence", expq.size(), 0);
    chk(last_acc[2] > last_acc[100], "R7", "diag off before sleep write", last_acc[2] - last_acc[100], 1);
    chk(last_acc[119] - last_acc[2] >= 20*CPM && last_acc[119] - last_acc[2] <= 20*CPM + SLACK,
        "R7", "drain wait before status read", last_acc[119] - last_acc[2], 20*CPM);
    chk(clk_en == 0 && clk_fall > last_acc[119], "R8", "clock stops after status read",
        int'(clk_en), 0);

    // later wake skips setup
    s115 = last_acc[115];
    push_exp(1, 2, cfg_wake_word);
    push_exp(1, 100, cfg_diag_on);
    pulse_record();
    wait_mode(3, 20*CPM, "R9");
    chk(expq.size() == 0 && last_acc[115] == s115, "R9", "rewake skips setup", last_acc[115] - s115, 0);
    chk(clk_en == 1 && last_acc[100] - clk_rise >= 10*CPM, "R6", "rewake bias wait",
        last_acc[100] - clk_rise, 10*CPM);

    // status retry
    statq.push_back(8'h00); statq.push_back(8'h7F); statq.push_back(8'h80);
    sleep_expect(3);
    r0 = n_reads;
    pulse_sleep();
    for (int i = 0; i < 40*CPM && n_reads < r0 + 2; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(clk_en == 1 && int'(mode) == 4, "R12", "clock held during retry", int'(clk_en), 1);
    wait_mode(2, 10*CPM, "R12");
    chk(n_reads - r0 == 3 && expq.size() == 0, "R12", "status reads until confirmed", n_reads - r0, 3);
    chk(last_rd - prev_rd >= CPM && last_rd - prev_rd <= CPM + SLACK, "R12", "retry spacing",
        last_rd - prev_rd, CPM);
    chk(clk_en == 0, "R8", "clock stopped after confirmation", int'(clk_en), 0);

    // retries exhausted
    push_exp(1, 2, cfg_wake_word);
    push_exp(1, 100, cfg_diag_on);
    pulse_record();
    wait_mode(3, 20*CPM, "R9");
    for (int i = 0; i <= RETRIES; i++) statq.push_back(8'h00);
    sleep_expect(RETRIES + 1);
    r0 = n_reads;
    pulse_sleep();
    for (int i = 0; i < 60*CPM && !fault; i++) @(negedge clk);
    chk(fault == 1 && int'(mode) == 5 && clk_en == 1, "R13", "fault after retries",
        {fault, mode}, 13);
    chk(n_reads - r0 == RETRIES + 1, "R12", "read count before fault", n_reads - r0, RETRIES + 1);
    a0 = acc_total; pulse_record(); repeat (40) @(negedge clk);
    chk(fault == 1 && int'(mode) == 5 && acc_total == a0, "R13", "fault sticky, record ignored",
        acc_total - a0, 0);

    // shutdown from fault, then restart with full setup
    req_shutdown = 1'b1;
    @(negedge clk);
    chk(shdn_n == 0 && clk_en == 0 && fault == 0 && mode == 3'd0, "R10", "shutdown response",
        {shdn_n, clk_en, fault}, 0);
    repeat (5) @(negedge clk);
    req_shutdown = 1'b0;
    boot_check();
    full_activation("R10");

    // shutdown during an active transition
    sleep_expect(1);
    pulse_sleep();
    for (int i = 0; i < 10*CPM && int'(mode) != 4; i++) @(negedge clk);
    repeat (CPM * 3) @(negedge clk);
    req_shutdown = 1'b1;
    @(negedge clk);
    chk(shdn_n == 0 && clk_en == 0 && mode == 3'd0, "R10", "shutdown mid-transition",
        {shdn_n, clk_en}, 0);
    expq.delete();
    req_shutdown = 1'b0;
    repeat (5) @(negedge clk);

    chk(inv_fail == 0, "R10", "no clock or command while shut down", inv_fail, 0);
    chk(hold_fail == 0, "R14", "valid held until ready", hold_fail, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule